// File: doc/BRIEF.md
# Quad I/O Continuous Read Engine

This block is the read side of an emulated serial flash device. It serves the quad I/O fast-read operation. The host opens a transaction by pulling chip select low and clocking an 8-bit opcode in on line 0, one bit per falling SCK edge. If the opcode is 0xEB, all four data lines switch to 4-bit transfers. The host then sends a 24-bit address, a mode byte and a run of dummy nibbles. After that, the block drives a stream of bytes read from a small on-chip array through a synchronous read port.

The upper nibble of the mode byte controls how the next transaction starts. If that nibble is 0xA, the block stays in quad mode when chip select rises, and the next transaction begins directly with the address, with no opcode. Any other value returns the block to opcode mode. While a write or erase is in progress elsewhere (input `wip_i`), the block sends zero bytes in place of array data.

SCK, chip select and the data lines are sampled in the system clock domain. The address width and the dummy length are parameters, so the same block can sit in front of a small test array.

Top module: `qspi_quad_read`

## Requirements
- R1: After reset, and before any transaction, `dq_o` is 0, `dq_oe_o` is 0 and `rd_en_o` is 0.
- R2: In opcode mode, the first 8 falling SCK edges of a transaction shift in `dq_i[0]`, MSB first. Only the value 0xEB starts a quad read. Any other value makes the rest of that transaction ignored: no read request and no output enable until chip select rises.
- R3: After the opcode (or from the first edge in continuous mode), the block takes 6 address nibbles, most significant nibble first, with `dq_i[3]` as the nibble's MSB. A read request for that address is issued right after the 6th address nibble. Only the low ADDR_W address bits are used; the bits above them are ignored.
- R4: The address is followed by 2 mode nibbles and DUMMY_NIB dummy nibbles. On the edge after the last dummy nibble, `dq_o` shows the high nibble of the first byte, and all four `dq_oe_o` bits rise. From then on, each falling edge presents the next nibble, high nibble before low nibble. `dq_o` changes only after a falling SCK edge.
- R5: Each byte sent advances the read address by one, wrapping modulo 2^ADDR_W.
- R6: If the captured mode byte has 0xA in its upper nibble, the next transaction carries no opcode. Its first 6 nibbles are the address.
- R7: Any other upper nibble of the mode byte makes the next transaction begin with a serial opcode again.
- R8: A quad transaction that ends before its mode byte is complete counts as not continuing. The next transaction begins with a serial opcode.
- R9: When `wip_i` is high on the edge that loads a byte, that byte is sent as 0x00, the read address does not advance and no read request is issued.
- R10: On the first clock where chip select is seen high, `dq_oe_o` and `dq_o` return to 0, and any partial transaction is dropped.
- R11: Every read request on `rd_en_o` is a single-cycle pulse. The array returns its data one clock later. There is one request for the address and one per byte loaded without WIP; the byte for each boundary is fetched one boundary early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SCK high and low phases must each last at least 2 cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select; SCK must be high when it falls |
| sck_i | input | 1 | Serial clock; all activity happens on its falling edge |
| dq_i | input | 4 | Incoming data lines (line 0 only during the opcode) |
| dq_o | output | 4 | Outgoing nibble |
| dq_oe_o | output | 4 | Output enable per data line |
| wip_i | input | 1 | Write-in-progress flag; substitutes zero bytes |
| rd_en_o | output | 1 | Array read request |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array read data, valid one clock after the request |

## Verification
The bench uses ADDR_W = 10 and DUMMY_NIB = 4. With a 10-bit address, a five-byte burst starting at 0x3FE crosses the wrap to 0. A 24-bit address with its upper bits set shows that those bits are ignored. Four dummy nibbles put the first data byte at the same edges as the default build. This lets the bench step through opcode-led, continuous and aborted transactions, with WIP asserted on the first byte and on a byte in mid-stream, all within a few thousand clocks.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  typedef enum logic [1:0] {
    QS_SER   = 2'd0,
    QS_SKIP  = 2'd1,
    QS_QCMD  = 2'd2,
    QS_QADDR = 2'd3
  } qcr_state_e;

  localparam logic [7:0] QREAD_OP = 8'hEB;
  localparam logic [3:0] CONT_KEY = 4'hA;

  // bit positions counted as if an opcode were present
  localparam int unsigned POS_CMD  = 8;
  localparam int unsigned POS_ADDR = 32;
  localparam int unsigned POS_MODE = 40;
endpackage

// File: rtl/qcr_sck_edge.sv
module qcr_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  output logic fall_o,
  output logic cs_rise_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= cs_ni | sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign fall_o    = !cs_ni && sck_q && !sck_i;
  assign cs_rise_o = cs_ni && !cs_q;
endmodule

// File: rtl/qcr_ctrl.sv
module qcr_ctrl
  import qcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DUMMY_NIB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              fall_i,
  input  logic              cs_rise_i,
  input  logic [3:0]        dq_i,
  output logic              qedge_o,
  output logic              addr_ld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bnd_o,
  output logic              oe_o
);
  localparam int unsigned PDATA = POS_MODE + 4 * DUMMY_NIB;
  localparam int unsigned PTOP  = PDATA + 8;
  localparam int unsigned CW    = $clog2(PTOP + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t C_CMD  = cnt_t'(POS_CMD);
  localparam cnt_t C_ADDR = cnt_t'(POS_ADDR);
  localparam cnt_t C_MODE = cnt_t'(POS_MODE);
  localparam cnt_t C_DATA = cnt_t'(PDATA);
  localparam cnt_t C_OE   = cnt_t'(PDATA + 4);
  localparam cnt_t C_TOP  = cnt_t'(PTOP);

  qcr_state_e  state_q;
  cnt_t        cnt_q, cnt_inc;
  logic [23:0] in_q, in_nxt;
  logic [7:0]  ser_nxt;
  logic [3:0]  key_q;
  logic        oe_q, quad, cont_go;

  assign quad    = (state_q == QS_QCMD) || (state_q == QS_QADDR);
  assign cont_go = (key_q == CONT_KEY);
  // data region alternates between TOP-4 and TOP so the counter never grows
  assign cnt_inc = (cnt_q == C_TOP) ? C_TOP - cnt_t'(4) : cnt_q + cnt_t'(4);
  assign in_nxt  = {in_q[19:0], dq_i};
  assign ser_nxt = {in_q[6:0], dq_i[0]};

  assign qedge_o   = fall_i && quad;
  assign addr_ld_o = qedge_o && (cnt_inc == C_ADDR);
  assign addr_o    = in_nxt[ADDR_W-1:0];
  assign bnd_o     = qedge_o && (cnt_inc >= C_DATA) && (cnt_inc[2:0] == 3'd0);
  assign oe_o      = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= QS_SER;
      cnt_q   <= '0;
      in_q    <= '0;
      key_q   <= '0;
      oe_q    <= 1'b0;
    end else if (cs_ni) begin
      in_q <= '0;
      oe_q <= 1'b0;
      if (cs_rise_i) begin
        key_q <= '0;
        if (quad && cont_go) begin
          state_q <= QS_QADDR;
          cnt_q   <= C_CMD;
        end else begin
          state_q <= QS_SER;
          cnt_q   <= '0;
        end
      end else begin
        cnt_q <= (state_q == QS_QADDR) ? C_CMD : '0;
      end
    end else if (fall_i) begin
      unique case (state_q)
        QS_SER: begin
          in_q  <= {16'h0, ser_nxt};
          cnt_q <= cnt_q + cnt_t'(1);
          if (cnt_q == C_CMD - cnt_t'(1))
            state_q <= (ser_nxt == QREAD_OP) ? QS_QCMD : QS_SKIP;
        end
        QS_SKIP: ;
        default: begin
          in_q  <= in_nxt;
          cnt_q <= cnt_inc;
          if (cnt_inc == C_MODE) key_q <= in_nxt[7:4];
          if (cnt_inc == C_OE)   oe_q  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/qcr_fetch.sv
module qcr_fetch #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bnd_i,
  input  logic              wip_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_en_q;

  // the byte consumed at a boundary was requested at the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rd_en_q <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      if (addr_ld_i) begin
        addr_q  <= addr_i;
        rd_en_q <= 1'b1;
      end else if (bnd_i && !wip_i) begin
        addr_q  <= addr_q + ADDR_W'(1);
        rd_en_q <= 1'b1;
      end
    end
  end

  assign rd_en_o   = rd_en_q;
  assign rd_addr_o = addr_q;
endmodule

// File: rtl/qcr_txshift.sv
module qcr_txshift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       qedge_i,
  input  logic       bnd_i,
  input  logic       wip_i,
  input  logic [7:0] rd_data_i,
  output logic [3:0] dq_o
);
  logic [11:0] sr_q;
  logic [7:0]  ld_byte;

  assign ld_byte = wip_i ? 8'h00 : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (cs_ni)   sr_q <= '0;
    else if (qedge_i) sr_q <= bnd_i ? {sr_q[7:4], ld_byte} : {sr_q[7:0], 4'h0};
  end

  assign dq_o = sr_q[11:8];
endmodule

// File: rtl/qspi_quad_read.sv
module qspi_quad_read
  import qcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DUMMY_NIB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  input  logic              wip_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic              sck_fall, cs_rise, qedge, addr_ld, data_bnd, oe;
  logic [ADDR_W-1:0] addr_new;

  qcr_sck_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .sck_i     (sck_i),
    .fall_o    (sck_fall),
    .cs_rise_o (cs_rise)
  );

  qcr_ctrl #(.ADDR_W(ADDR_W), .DUMMY_NIB(DUMMY_NIB)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .fall_i    (sck_fall),
    .cs_rise_i (cs_rise),
    .dq_i      (dq_i),
    .qedge_o   (qedge),
    .addr_ld_o (addr_ld),
    .addr_o    (addr_new),
    .bnd_o     (data_bnd),
    .oe_o      (oe)
  );

  qcr_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_ld_i (addr_ld),
    .addr_i    (addr_new),
    .bnd_i     (data_bnd),
    .wip_i     (wip_i),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o)
  );

  qcr_txshift u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .qedge_i   (qedge),
    .bnd_i     (data_bnd),
    .wip_i     (wip_i),
    .rd_data_i (rd_data_i),
    .dq_o      (dq_o)
  );

  assign dq_oe_o = {4{oe}};
endmodule

// File: rtl/qcr_chk.sv
module qcr_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sck_i,
  input logic              wip_i,
  input logic [3:0]        dq_o,
  input logic [3:0]        dq_oe_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              bnd_i
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> (dq_oe_o == 4'h0 && dq_o == 4'h0));

  // R4
  edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni) && !($past(sck_i) && !sck_i)) |=> ($stable(dq_o) && $stable(dq_oe_o)));

  // R4
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o[0]) |-> (!$past(sck_i) && !$past(cs_ni)));

  // R11
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  // R3
  rd_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> !$past(cs_ni));

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && !wip_i) |=> (rd_en_o && rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1)));

  // R9
  wip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && wip_i) |=> (!rd_en_o && $stable(rd_addr_o)));
endmodule

bind qspi_quad_read qcr_chk #(.ADDR_W(ADDR_W)) u_qcr_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sck_i     (sck_i),
  .wip_i     (wip_i),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .bnd_i     (data_bnd)
);

// File: tb/qspi_quad_read_tb.sv
module qspi_quad_read_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned DN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sck = 1'b1;
  logic          wip = 1'b0;
  logic [3:0]    dq_in = 4'h0;
  logic [3:0]    dq_out, dq_oe;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  int    n_chk = 0, n_err = 0, rd_cnt = 0;
  logic  [3:0] exp_dq = 4'h0;
  logic  exp_oe = 1'b0;
  bit    chk_on = 1'b0;
  bit    cont = 1'b0;
  string req = "R1";

  always #10 clk = ~clk;

  qspi_quad_read #(.ADDR_W(AW), .DUMMY_NIB(DN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .wip_i(wip),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] mem_at(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // synchronous array, one clock of latency
  always @(posedge clk) if (rd_en) rd_data <= mem_at(int'(rd_addr));
  always @(posedge clk) if (rst_n && rd_en) rd_cnt++;

  // per-clock comparison against the bench model
  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (dq_out !== exp_dq || dq_oe !== {4{exp_oe}}) begin
        n_err++;
        $display("FAIL %s: dq=%h oe=%h expected dq=%h oe=%h at %0t",
                 req, dq_out, dq_oe, exp_dq, {4{exp_oe}}, $time);
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // one SCK period: low 2 clocks, high 2 clocks; outputs update on the fall
  task automatic fall(input logic [3:0] nib, input logic w, input logic [3:0] ndq, input logic noe);
    @(negedge clk);
    sck = 1'b0; dq_in = nib; wip = w;
    @(posedge clk);
    #1;
    exp_dq = ndq; exp_oe = noe;
    @(negedge clk);
    @(negedge clk);
    sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_high();
    string keep;
    keep = req;
    req = "R10";
    @(negedge clk);
    cs_n = 1'b1; sck = 1'b1; wip = 1'b0;
    @(posedge clk);
    #1;
    exp_dq = 4'h0; exp_oe = 1'b0;
    repeat (3) @(negedge clk);
    req = keep;
  endtask

  task automatic ser_cmd(input logic [7:0] cmd);
    for (int i = 7; i >= 0; i--) fall({3'b010, cmd[i]}, 1'b0, 4'h0, 1'b0);
  endtask

  // full read; wip_k selects the byte loaded under WIP (-1: none)
  task automatic rd_xfer(input logic [23:0] addr, input logic [7:0] mode, input int nbytes, input int wip_k);
    int a, r0, exp_rd, loads;
    logic [7:0] b;
    r0 = rd_cnt;
    cs_low();
    if (!cont) ser_cmd(8'hEB);
    for (int i = 5; i >= 0; i--) fall(addr[i*4 +: 4], 1'b0, 4'h0, 1'b0);
    fall(mode[7:4], 1'b0, 4'h0, 1'b0);
    fall(mode[3:0], 1'b0, 4'h0, 1'b0);
    for (int i = 0; i < int'(DN); i++) fall(4'h3, (i == int'(DN) - 1) && (wip_k == 0), 4'h0, 1'b0);
    a = int'(addr) % (1 << AW);
    loads = nbytes + 1;
    if (wip_k >= 0 && wip_k <= nbytes) loads--;
    exp_rd = 1 + loads;
    for (int k = 0; k < nbytes; k++) begin
      if (k == wip_k) b = 8'h00;
      else begin
        b = mem_at(a);
        a = (a + 1) % (1 << AW);
      end
      fall(4'h5, 1'b0, b[7:4], 1'b1);
      fall(4'hC, (k + 1) == wip_k, b[3:0], 1'b1);
    end
    cs_high();
    cont = (mode[7:4] == 4'hA);
    check(rd_cnt - r0 == exp_rd, "R11", "read requests in transaction", rd_cnt - r0, exp_rd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    report();
    $finish;
  end

  initial begin : main
    int r0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dq_out == 4'h0, "R1", "dq_o in reset", int'(dq_out), 0);
    check(dq_oe == 4'h0, "R1", "dq_oe_o in reset", int'(dq_oe), 0);
    check(rd_en == 1'b0, "R1", "rd_en_o in reset", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dq_oe == 4'h0 && dq_out == 4'h0, "R1", "idle outputs after reset", int'({dq_oe, dq_out}), 0);
    chk_on = 1'b1;

    // R2 non-quad opcode is ignored
    req = "R2";
    r0 = rd_cnt;
    cs_low();
    ser_cmd(8'h0B);
    for (int i = 0; i < 24; i++) fall(4'hA, 1'b0, 4'h0, 1'b0);
    cs_high();
    check(rd_cnt == r0, "R2", "reads after rejected opcode", rd_cnt - r0, 0);

    // R3 upper address bits dropped, R4 data stream
    req = "R3/R4";
    rd_xfer(24'hABC123, 8'h00, 4, -1);

    // R5 wrap from top of array; arms continuous mode
    req = "R5";
    rd_xfer(24'h0003FE, 8'hA5, 5, -1);

    // R6 address-first transaction
    req = "R6";
    check(cont, "R6", "bench continuous flag", int'(cont), 1);
    rd_xfer(24'h000040, 8'hA0, 3, -1);

    // R9 WIP on a mid-stream byte and on the first byte
    req = "R9";
    rd_xfer(24'h000080, 8'hAF, 4, 2);
    rd_xfer(24'h000090, 8'hA3, 3, 0);

    // R8 abort in continuous mode before the mode byte
    req = "R8";
    cs_low();
    for (int i = 0; i < 3; i++) fall(4'h7, 1'b0, 4'h0, 1'b0);
    cs_high();
    cont = 1'b0;
    rd_xfer(24'h000200, 8'h5A, 2, -1);

    // R7 non-continuing mode returns to opcode mode
    req = "R7";
    check(!cont, "R7", "bench continuous flag", int'(cont), 0);
    rd_xfer(24'h000210, 8'h00, 2, -1);
    rd_xfer(24'h0003F0, 8'hA1, 2, -1);
    rd_xfer(24'h000005, 8'h70, 1, -1);

    chk_on = 1'b0;
    check(dq_oe == 4'h0 && rd_en == 1'b0, "R10", "idle after last transaction", int'(dq_oe), 0);
    report();
    $finish;
  end
endmodule